// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Bank

This block holds six 8-bit down-counting timers for a small controller. Each timer has a reload latch, a stop control, a selectable count source and an overflow request output. Some timers can take their count pulses from a neighbour's overflow, so the first timer of such a pair becomes an 8-bit prescaler. Software reaches the timers through a small register bus. The bus writes latches and mode registers and reads live counter values.

A shared prescaler divides a base tick by 2, 16 and 4096. The base tick is either every main-clock cycle or each rising edge of a sub-clock pin. Two external count pins and the sub-clock pin pass through two-flop synchronisers and a rising-edge detector. An external pin's high phase must last at least 4 clock cycles.

A three-state sequencer controls the internal-ready output. The states are ST_BOOT, ST_RUN and ST_WAKE.

- Reset enters ST_BOOT. Timer 3 is preset to 0xFF and timer 4 to 0x07, and timer 4 counts timer 3 overflows.
- An overflow of timer 4 moves ST_BOOT to ST_RUN.
- A wake request in ST_RUN moves to ST_WAKE. The wake request presets both timers again.
- Timer 3 keeps its software-selected source during ST_WAKE. An overflow of timer 4 moves ST_WAKE back to ST_RUN.

Top module: `tmr_bank`

## Requirements
- R1: After reset, `sys_ready` is 0 and `irq` is all zero. Both mode registers (address 6 and address 7) read 0x00. Timer 3 (address 2) reads 0xFF and timer 4 (address 3) reads 0x07.
- R2: In ST_BOOT, timer 3 counts clock/16 and timer 4 counts timer 3 overflows. `sys_ready` rises one cycle after the timer 4 overflow pulse, which is about 8·256·16 = 32768 cycles after reset. Bus writes are ignored while `sys_ready` is 0.
- R3: A timer with latch value n and a prescaled source of period D raises its `irq` bit every (n+1)·D cycles. The prescaled periods are D = 2, 16 and 4096.
- R4: A bus write to a timer address (0..5 for timers 1..6) loads the written value into both the latch and the counter at that clock edge.
- R5: An `irq` bit is a one-cycle pulse. It is raised on the count pulse that finds the counter at 0x00, and in that same cycle the counter reloads from the latch.
- R6: Control register bit i (address 7, bits 5:0, 1 = halt) freezes timer i+1. A frozen timer keeps its counter value and raises no `irq`.
- R7: Selecting a chained source makes a timer count its neighbour's overflows. The chained sources are: timer 2 from timer 1 (source bit 2 = 1); timer 5 from timer 4 (source bits 7:6 = 1x); timer 6 from timer 5 (control bit 6 = 1). The resulting period is the product of the stage periods.
- R8: An external pin source counts one step per rising edge of its pin. Timer 1 uses pin A when source bits 1:0 = 11. Timer 3 uses pin B when source bit 3 = 1.
- R9: Control bit 7 = 1 makes every prescaled source derive from sub-clock rising edges instead of main-clock cycles.
- R10: Timer 1 with source bits 1:0 = 10 counts sub-clock rising edges directly, without the prescaler.
- R11: `wake_req` in ST_RUN drops `sys_ready` at the next edge and presets timer 3 to 0xFF and timer 4 to 0x07. Timer 3 keeps its software source, and `sys_ready` returns after the next timer 4 overflow. Bus writes during this wait are ignored.
- R12: Timer 1 source bits 1:0 = 01 selects clock/4096. Timer 4 source bits 5:4 = 1x selects clock/2, and 00 selects timer 3 overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address: 0..5 timers, 6 source register, 7 control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (counter value or mode register) |
| pin_ext_a | input | 1 | External count pin A (timer 1) |
| pin_ext_b | input | 1 | External count pin B (timer 3) |
| pin_sub_clk | input | 1 | Sub-clock pin |
| wake_req | input | 1 | Stop-mode wakeup request pulse |
| irq | output | 6 | Per-timer overflow request pulses |
| sys_ready | output | 1 | Internal reset released |

## Verification
The divide function is tested several ways. Random latch values on the /16, /2 and /4096 taps confirm the (n+1)·D law and catch off-by-one reload errors. Two-stage and three-stage chains separate a correct cascade from a wrong overflow tap. External pin, direct sub-clock and sub-clock-based inputs show that each source mux leg and the base select reach the right counter. The boot and wake sequences are timed against the expected 8·256 source periods. A held-stop timer and ignored writes during the sequence show that control state is not disturbed.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
    localparam int TMR_W   = 8;
    localparam int NUM_TMR = 6;
    localparam int ADDR_W  = 4;
    localparam int ADDR_SRC = 6;
    localparam int ADDR_CTL = 7;
    localparam int NUM_PINS = 3;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAKE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_FAST = 2,
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    output logic tick_fast,
    output logic tick_mid,
    output logic tick_slow
);
    localparam int FAST_B = $clog2(DIV_FAST);
    localparam int MID_B  = $clog2(DIV_MID);
    localparam int SLOW_B = $clog2(DIV_SLOW);

    logic [SLOW_B-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (base_tick)
            pre_q <= pre_q + 1'b1;
    end

    assign tick_fast = base_tick & (&pre_q[FAST_B-1:0]);
    assign tick_mid  = base_tick & (&pre_q[MID_B-1:0]);
    assign tick_slow = base_tick & (&pre_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         halt,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic [W-1:0] latch_q, cnt_q;
    logic         ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= RST_VAL;
            cnt_q   <= RST_VAL;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (preset_en) begin
                latch_q <= RST_VAL;
                cnt_q   <= RST_VAL;
            end else if (load_en) begin
                latch_q <= load_val;
                cnt_q   <= load_val;
            end else if (tick && !halt) begin
                if (cnt_q == '0) begin
                    cnt_q <= latch_q;
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_bank_pkg::*;
#(
    parameter int DIV_FAST = 2,
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 4096,
    parameter logic [7:0] BOOT_VAL_A = 8'hFF,
    parameter logic [7:0] BOOT_VAL_B = 8'h07
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [TMR_W-1:0]    bus_wdata,
    output logic [TMR_W-1:0]    bus_rdata,
    input  logic                pin_ext_a,
    input  logic                pin_ext_b,
    input  logic                pin_sub_clk,
    input  logic                wake_req,
    output logic [NUM_TMR-1:0]  irq,
    output logic                sys_ready
);
    localparam int IDX_T3 = 2;
    localparam int IDX_T4 = 3;

    seq_state_t state_q, state_d;
    logic       seq_force;
    logic       preset_go;

    logic [7:0] src_q, ctl_q;
    logic [NUM_PINS-1:0] pins_in, pin_rise;
    logic base_tick, tick_fast, tick_mid, tick_slow;
    logic [NUM_TMR-1:0] tmr_tick, tmr_halt, tmr_ovf, tmr_load, tmr_preset;
    logic [TMR_W-1:0]   tmr_cnt [NUM_TMR];
    logic [NUM_TMR*TMR_W-1:0] cnt_all;

    // sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_BOOT;
        else
            state_q <= state_d;
    end

    // sequencer: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (tmr_ovf[IDX_T4]) state_d = ST_RUN;
            ST_RUN:  if (wake_req)        state_d = ST_WAKE;
            ST_WAKE: if (tmr_ovf[IDX_T4]) state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // sequencer: outputs
    always_comb begin
        sys_ready = 1'b0;
        seq_force = 1'b1;
        preset_go = 1'b0;
        unique case (state_q)
            ST_BOOT: ;
            ST_RUN: begin
                sys_ready = 1'b1;
                seq_force = 1'b0;
                preset_go = wake_req;
            end
            ST_WAKE: ;
            default: ;
        endcase
    end

    // mode registers, writable only while internal reset is released
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= 8'h00;
            ctl_q <= 8'h00;
        end else if (sys_ready && bus_we) begin
            if (bus_addr == ADDR_W'(ADDR_SRC)) src_q <= bus_wdata;
            if (bus_addr == ADDR_W'(ADDR_CTL)) ctl_q <= bus_wdata;
        end
    end

    // pin synchronisers: 0 = ext A, 1 = ext B, 2 = sub-clock
    assign pins_in = {pin_sub_clk, pin_ext_b, pin_ext_a};

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
        tmr_edge_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (pins_in[p]),
            .rise     (pin_rise[p])
        );
    end

    assign base_tick = ctl_q[7] ? pin_rise[2] : 1'b1;

    tmr_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .tick_fast (tick_fast),
        .tick_mid  (tick_mid),
        .tick_slow (tick_slow)
    );

    // count source selection
    always_comb begin
        unique case (src_q[1:0])
            2'b00: tmr_tick[0] = tick_mid;
            2'b01: tmr_tick[0] = tick_slow;
            2'b10: tmr_tick[0] = pin_rise[2];
            default: tmr_tick[0] = pin_rise[0];
        endcase
        tmr_tick[1] = src_q[2] ? tmr_ovf[0] : tick_mid;
        tmr_tick[2] = src_q[3] ? pin_rise[1] : tick_mid;
        if (seq_force) begin
            tmr_tick[3] = tmr_ovf[2];
        end else begin
            unique case (src_q[5:4])
                2'b00: tmr_tick[3] = tmr_ovf[2];
                2'b01: tmr_tick[3] = tick_mid;
                default: tmr_tick[3] = tick_fast;
            endcase
        end
        unique case (src_q[7:6])
            2'b00: tmr_tick[4] = tick_mid;
            2'b01: tmr_tick[4] = pin_rise[2];
            default: tmr_tick[4] = tmr_ovf[3];
        endcase
        tmr_tick[5] = ctl_q[6] ? tmr_ovf[4] : tick_mid;
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam logic [TMR_W-1:0] RV = (i == IDX_T3) ? BOOT_VAL_A :
                                          (i == IDX_T4) ? BOOT_VAL_B : '0;
        localparam bit SEQ_MEMBER = (i == IDX_T3) || (i == IDX_T4);

        assign tmr_halt[i]   = SEQ_MEMBER ? (ctl_q[i] & ~seq_force) : ctl_q[i];
        assign tmr_preset[i] = SEQ_MEMBER ? preset_go : 1'b0;
        assign tmr_load[i]   = sys_ready & bus_we & (bus_addr == ADDR_W'(i));

        tmr_unit #(
            .W       (TMR_W),
            .RST_VAL (RV)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .preset_en (tmr_preset[i]),
            .load_en   (tmr_load[i]),
            .load_val  (bus_wdata),
            .tick      (tmr_tick[i]),
            .halt      (tmr_halt[i]),
            .cnt       (tmr_cnt[i]),
            .ovf       (tmr_ovf[i])
        );

        assign cnt_all[i*TMR_W +: TMR_W] = tmr_cnt[i];
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = tmr_cnt[i];
        end
        if (bus_addr == ADDR_W'(ADDR_SRC)) bus_rdata = src_q;
        if (bus_addr == ADDR_W'(ADDR_CTL)) bus_rdata = ctl_q;
    end

    assign irq = tmr_ovf;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_bank_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [TMR_W-1:0]           bus_wdata,
    input logic                       wake_req,
    input logic [NUM_TMR-1:0]         irq,
    input logic                       sys_ready,
    input logic [7:0]                 ctl_q,
    input logic [NUM_TMR*TMR_W-1:0]   cnt_all
);
    // R2: internal ready is released only after a timer 4 overflow pulse
    a_r2_ready_after_t4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_ready) |-> $past(irq[3]));

    // R11: a wake request drops ready at the next edge
    a_r11_wake_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_ready && wake_req) |=> !sys_ready);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        // R5: overflow requests are single-cycle pulses
        a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |=> !irq[i]);

        // R4: a latch write lands in the counter at that edge
        a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
            (sys_ready && bus_we && bus_addr == ADDR_W'(i) && !wake_req)
            |=> (cnt_all[i*TMR_W +: TMR_W] == $past(bus_wdata)));

        // R6: a halted timer holds its count
        a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (sys_ready && ctl_q[i] && !wake_req && !(bus_we && bus_addr == ADDR_W'(i)))
            |=> $stable(cnt_all[i*TMR_W +: TMR_W]));
    end
endmodule

bind tmr_bank tmr_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wake_req  (wake_req),
    .irq       (irq),
    .sys_ready (sys_ready),
    .ctl_q     (ctl_q),
    .cnt_all   (cnt_all)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pin_ext_a = 1'b0;
    logic       pin_ext_b = 1'b0;
    logic       pin_sub_clk = 1'b0;
    logic       wake_req = 1'b0;
    logic [5:0] irq;
    logic       sys_ready;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int per_a = 0, per_b = 0, per_s = 0;
    logic [7:0] src_sh = 8'h00, ctl_sh = 8'h00;
    bit done = 1'b0;

    tmr_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_ext_a   (pin_ext_a),
        .pin_ext_b   (pin_ext_b),
        .pin_sub_clk (pin_sub_clk),
        .wake_req    (wake_req),
        .irq         (irq),
        .sys_ready   (sys_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // pin pattern generators, driven away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        pin_ext_a   <= (per_a != 0) && ((cyc % per_a) < per_a / 2);
        pin_ext_b   <= (per_b != 0) && ((cyc % per_b) < per_b / 2);
        pin_sub_clk <= (per_s != 0) && ((cyc % per_s) < per_s / 2);
    end

    function automatic int exp_period(input int n, input int d);
        return (n + 1) * d;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input int got, input int expv);
        n_checks++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic chk_range(input string req, input int got, input int lo, input int hi);
        n_checks++;
        if (got < lo || got > hi) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic set_src(input logic [7:0] v);
        src_sh = v; wr(4'd6, v);
    endtask

    task automatic set_ctl(input logic [7:0] v);
        ctl_sh = v; wr(4'd7, v);
    endtask

    // cycles between the second and third pulse of irq[idx]
    task automatic meas(input int idx, input int limit, output int per);
        int seen = 0, t = 0, t2 = 0;
        per = -1;
        while (seen < 3 && t < limit) begin
            @(negedge clk);
            t++;
            if (irq[idx]) begin
                seen++;
                if (seen == 2) t2 = t;
                if (seen == 3) per = t - t2;
            end
        end
    endtask

    task automatic wait_ready(input int limit, output int t);
        t = 0;
        while (!sys_ready && t < limit) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        int v, p, t, n;
        void'($urandom(32'd5150));
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", int'(sys_ready), 0);
        chk("R1 irq", int'(irq), 0);
        rd(4'd6, v); chk("R1 src reg", v, 0);
        rd(4'd7, v); chk("R1 ctl reg", v, 0);
        rd(4'd2, v); chk("R1 t3 preset", v, 8'hFF);
        rd(4'd3, v); chk("R1 t4 preset", v, 8'h07);
        rst_n = 1'b1;
        // R2 write during boot ignored
        wr(4'd6, 8'h55);
        wait_ready(40000, t);
        chk_range("R2 boot delay", t + 2, 32770 - 4, 32770 + 4);
        rd(4'd6, v); chk("R2 write ignored in boot", v, 0);

        // R3 timer 1 on /16, timer 4 on /2 and timer 6 on /16 with random latches
        for (int k = 0; k < 5; k++) begin
            n = int'($urandom % 32);
            set_src(8'h00);
            wr(4'd0, 8'(n));
            meas(0, 4 * exp_period(n, 16) + 200, p);
            chk("R3 t1 /16 period", p, exp_period(n, 16));
            n = int'($urandom % 64);
            set_src(8'h20);
            wr(4'd3, 8'(n));
            meas(3, 4 * exp_period(n, 2) + 200, p);
            chk("R12 t4 /2 period", p, exp_period(n, 2));
            n = int'($urandom % 48);
            wr(4'd5, 8'(n));
            meas(5, 4 * exp_period(n, 16) + 200, p);
            chk("R3 t6 /16 period", p, exp_period(n, 16));
        end
        // R12 /4096 on timer 1
        set_src(8'h01);
        wr(4'd0, 8'd0);
        meas(0, 4 * 4096 + 200, p);
        chk("R12 t1 /4096 period", p, 4096);

        // R5 reload visible with the pulse
        set_src(8'h00);
        wr(4'd0, 8'd9);
        bus_addr = 4'd0;
        t = 0;
        while (!irq[0] && t < 1000) begin @(negedge clk); t++; end
        rd(4'd0, v); chk("R5 reload with pulse", v, 9);
        @(negedge clk);
        chk("R5 pulse one cycle", int'(irq[0]), 0);

        // R7 chain t1 -> t2
        set_src(8'h04);
        wr(4'd0, 8'd3);
        wr(4'd1, 8'd4);
        meas(1, 4 * 320 + 400, p);
        chk("R7 t1->t2 chain", p, exp_period(3, 16) * 5);
        // R7 chain t4(/2) -> t5 -> t6
        set_src(8'hA0);
        set_ctl(8'h40);
        wr(4'd3, 8'd1);
        wr(4'd4, 8'd2);
        wr(4'd5, 8'd1);
        meas(5, 500, p);
        chk("R7 t4->t5->t6 chain", p, 2 * 2 * 3 * 2);

        // R6 halt: stop timer 2 and check it holds
        set_ctl(8'h42);
        rd(4'd1, v);
        t = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (irq[1]) t++;
        end
        rd(4'd1, n);
        chk("R6 halted count holds", n, v);
        chk("R6 halted no irq", t, 0);
        // R4 latch write loads counter (halted, so no tick interferes)
        wr(4'd1, 8'h5A);
        rd(4'd1, v); chk("R4 latch to counter", v, 8'h5A);
        set_ctl(8'h40);

        // R8 ext pin A on timer 1
        per_a = 10;
        set_src(8'h03);
        wr(4'd0, 8'd3);
        meas(0, 2000, p);
        chk("R8 t1 ext A period", p, exp_period(3, 10));
        per_a = 0;

        // R10 sub-clock direct on timer 1
        per_s = 6;
        set_src(8'h02);
        wr(4'd0, 8'd4);
        meas(0, 1000, p);
        chk("R10 t1 sub direct", p, exp_period(4, 6));

        // R9 base from sub-clock: timer 6 on /16
        per_s = 4;
        set_ctl(8'h80);
        wr(4'd5, 8'd2);
        meas(5, 3000, p);
        chk("R9 sub base /16", p, exp_period(2, 16) * 4);
        set_ctl(8'h00);
        per_s = 0;

        // R11 wake: timer 3 kept on ext B and halted by software
        per_b = 8;
        set_src(8'h08);
        set_ctl(8'h04);
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk("R11 ready drops", int'(sys_ready), 0);
        rd(4'd2, v); chk("R11 t3 preset", v, 8'hFF);
        rd(4'd3, v); chk("R11 t4 preset", v, 8'h07);
        wr(4'd6, 8'hFF);
        wait_ready(30000, t);
        chk_range("R11 wake delay on ext B", t + 3, 16384 - 8, 16384 + 24);
        rd(4'd6, v); chk("R11 write ignored in wake", v, 8'h08);
        rd(4'd7, v); chk("R11 ctl kept", v, 8'h04);
        per_b = 0;

        done = 1'b1;
        summary();
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", WATCHDOG);
            summary();
        end
    end
endmodule